// File: doc/BRIEF.md
# PLL Configuration Writer with Readback

This block programs a set of external clock-synthesizer devices over a serial link. Each device has a small bank of setting registers. When a change request arrives, the controller captures the setting words for every device. It writes all of the device's registers, then reads each one back and compares the returned byte with the value it wrote. If every byte matches, the pass is reported as complete. A mismatch makes the controller repeat the whole write-and-verify pass a limited number of times. After that it reports a lasting failure.

All devices share one serial clock and one active-low select line, and each device has its own data-out and data-in line, so every device is programmed in the same frame slots. The block also produces a reference strobe for each device's reference input. It detects the rising edge of the frame-sync signal of the matching line bus and emits a one-cycle pulse. With 8 kHz frame timing, this gives one pulse every 125 microseconds.

Top module: `pllcfg_ctrl`

## Requirements
- R1: While reset is held: `pll_csn` is 1, `pll_sclk` is 0, and `cfg_done`, `cfg_err` and every `pll_ref` bit are 0.
- R2: Each frame is 16 bits sent MSB first while `pll_csn` is low. Bit 15 is the direction flag (1 = read, 0 = write), bits 14:8 are the register address and bits 7:0 are the data. `pll_sclk` is low whenever `pll_csn` is high. Data out changes only while the serial clock is low, and the data-in line is sampled on each rising serial clock edge.
- R3: A pass issues four write frames to addresses REG_BASE, REG_BASE+1, REG_BASE+2, REG_BASE+3, in ascending order (0x10 to 0x13 by default). It then issues four read frames to the same addresses in the same order.
- R4: The byte for device d, register r is `cfg_words[(d*N_REG+r)*8 +: 8]`, and it is sent only on `pll_mosi[d]`.
- R5: In a read frame, the last 8 bits sampled from `pll_miso[d]` form the returned byte. If every returned byte of every device equals the written value, `cfg_done` rises.
- R6: A pass with any mismatch is followed by a new pass starting from the first write. At most 3 such repeats occur, so one request produces at most 32 frames.
- R7: If the fourth pass also mismatches, `cfg_err` goes to 1 with `cfg_done` 0, no further frames are issued, and `cfg_err` stays set until the next request is accepted.
- R8: A one-cycle `cfg_req` pulse while the block is idle starts a pass. `cfg_done` and `cfg_err` are cleared within two clock edges of the pulse.
- R9: A request made during a pass is not lost. When the pass finishes, a new pass starts using the `cfg_words` values present at that time.
- R10: A rising edge on `fsync[i]` yields a single-cycle pulse on `pll_ref[i]`, high in the cycle after the third clock edge that follows the change. A held level yields no further pulse, and buses are independent.
- R11: `cfg_done` and `cfg_err` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_words | input | N_DEV*N_REG*8 | Setting bytes for all devices and registers |
| cfg_req | input | 1 | Change request pulse |
| fsync | input | N_DEV | Frame-sync signal of each line bus |
| pll_ref | output | N_DEV | Reference strobe for each device |
| pll_sclk | output | 1 | Shared serial clock, idle low |
| pll_csn | output | 1 | Shared active-low select |
| pll_mosi | output | N_DEV | Serial data to each device |
| pll_miso | input | N_DEV | Serial data from each device |
| cfg_done | output | 1 | Last pass verified cleanly |
| cfg_err | output | 1 | Retries exhausted |

## Verification
The bench attaches a behavioural model of each device. The model can corrupt the byte written to one register for a chosen number of passes. This exposes a design that never retries (error after one pass), one that retries forever or once too often (wrong frame count), and one that keeps sending frames after giving up. A request pulsed in the middle of a pass checks that a design dropping it would leave the old bytes in the devices. The frame log checks the read/write flag and the address order, catching swapped phases or descending addresses. The strobe checks look for a pulse that is too wide, repeats on a held level, arrives in the wrong cycle, or leaks onto the other bus.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

    localparam int FRAME_BITS = 16;
    localparam int DATA_BITS  = 8;
    localparam int ADDR_BITS  = 7;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_LAUNCH = 2'd1,
        SQ_WAIT   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/pllcfg_refgen.sv
module pllcfg_refgen #(
    parameter int N_BUS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_BUS-1:0] fsync,
    output logic [N_BUS-1:0] ref_pulse
);

    typedef struct packed {
        logic [N_BUS-1:0] meta;
        logic [N_BUS-1:0] sync;
        logic [N_BUS-1:0] last;
        logic [N_BUS-1:0] strobe;
    } ref_t;

    ref_t q, n;

    always_comb begin
        n        = q;
        n.meta   = fsync;
        n.sync   = q.meta;
        n.last   = q.sync;
        n.strobe = q.sync & ~q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign ref_pulse = q.strobe;

    for (genvar i = 0; i < N_BUS; i++) begin : g_chk
        AST_REF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            ref_pulse[i] |=> !ref_pulse[i]); // R10
    end

endmodule

// File: rtl/pllcfg_serial.sv
module pllcfg_serial
    import pllcfg_pkg::*;
#(
    parameter int N_DEV = 2,
    parameter int HALF  = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic [N_DEV-1:0][FRAME_BITS-1:0]     tx_frame,
    input  logic [N_DEV-1:0]                     miso,
    output logic                                 sclk,
    output logic                                 csn,
    output logic [N_DEV-1:0]                     mosi,
    output logic [N_DEV-1:0][DATA_BITS-1:0]      rx_byte,
    output logic                                 fin
);

    localparam int TICK_W = (2*HALF > 2) ? $clog2(2*HALF) : 1;
    localparam int BIT_W  = $clog2(FRAME_BITS);
    localparam logic [TICK_W-1:0] TICK_RISE = TICK_W'(HALF - 1);
    localparam logic [TICK_W-1:0] TICK_FALL = TICK_W'(2*HALF - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                               active;
        logic [TICK_W-1:0]                  tick;
        logic [BIT_W-1:0]                   bitn;
        logic [N_DEV-1:0][FRAME_BITS-1:0]   tx;
        logic [N_DEV-1:0][DATA_BITS-1:0]    rx;
        logic                               sclk;
        logic                               csn;
        logic                               fin;
    } ser_t;

    ser_t q, n;

    always_comb begin
        n     = q;
        n.fin = 1'b0;
        if (!q.active) begin
            if (start) begin
                n.active = 1'b1;
                n.tx     = tx_frame;
                n.csn    = 1'b0;
                n.tick   = '0;
                n.bitn   = '0;
            end
        end else if (q.tick == TICK_RISE) begin
            n.sclk = 1'b1;
            n.tick = q.tick + 1'b1;
            for (int d = 0; d < N_DEV; d++) begin
                n.rx[d] = {q.rx[d][DATA_BITS-2:0], miso[d]};
            end
        end else if (q.tick == TICK_FALL) begin
            n.sclk = 1'b0;
            n.tick = '0;
            n.bitn = q.bitn + 1'b1;
            for (int d = 0; d < N_DEV; d++) begin
                n.tx[d] = {q.tx[d][FRAME_BITS-2:0], 1'b0};
            end
            if (q.bitn == BIT_LAST) begin
                n.active = 1'b0;
                n.csn    = 1'b1;
                n.fin    = 1'b1;
            end
        end else begin
            n.tick = q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.csn <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign sclk    = q.sclk;
    assign csn     = q.csn;
    assign fin     = q.fin;
    assign rx_byte = q.rx;
    for (genvar d = 0; d < N_DEV; d++) begin : g_mosi
        assign mosi[d] = q.tx[d][FRAME_BITS-1];
    end

    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !csn); // R2
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R2
    AST_FIN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (csn && !sclk)); // R2

endmodule

// File: rtl/pllcfg_ctrl.sv
module pllcfg_ctrl
    import pllcfg_pkg::*;
#(
    parameter int              N_DEV     = 2,
    parameter int              N_REG     = 4,
    parameter logic [6:0]      REG_BASE  = 7'h10,
    parameter int              HALF      = 2,
    parameter int              MAX_RETRY = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_DEV*N_REG*8-1:0]    cfg_words,
    input  logic                        cfg_req,
    input  logic [N_DEV-1:0]            fsync,
    output logic [N_DEV-1:0]            pll_ref,
    output logic                        pll_sclk,
    output logic                        pll_csn,
    output logic [N_DEV-1:0]            pll_mosi,
    input  logic [N_DEV-1:0]            pll_miso,
    output logic                        cfg_done,
    output logic                        cfg_err
);

    localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1;
    localparam int RTY_W = $clog2(MAX_RETRY + 1) + 1;
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(N_REG - 1);
    localparam logic [RTY_W-1:0] RTY_LIMIT = RTY_W'(MAX_RETRY);

    typedef struct packed {
        seq_state_e                                  st;
        logic                                        rd_phase;
        logic [IDX_W-1:0]                            idx;
        logic [RTY_W-1:0]                            retry;
        logic                                        miss;
        logic                                        pend;
        logic                                        done;
        logic                                        err;
        logic                                        start;
        logic [N_DEV-1:0][N_REG-1:0][DATA_BITS-1:0]  shadow;
    } seq_t;

    seq_t q, n;

    logic [N_DEV-1:0][FRAME_BITS-1:0] tx_frame;
    logic [N_DEV-1:0][DATA_BITS-1:0]  ser_rx;
    logic                             ser_fin;

    pllcfg_refgen #(.N_BUS(N_DEV)) u_refgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .ref_pulse (pll_ref)
    );

    pllcfg_serial #(.N_DEV(N_DEV), .HALF(HALF)) u_serial (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (q.start),
        .tx_frame (tx_frame),
        .miso     (pll_miso),
        .sclk     (pll_sclk),
        .csn      (pll_csn),
        .mosi     (pll_mosi),
        .rx_byte  (ser_rx),
        .fin      (ser_fin)
    );

    always_comb begin
        for (int d = 0; d < N_DEV; d++) begin
            tx_frame[d] = {q.rd_phase,
                           REG_BASE + ADDR_BITS'(q.idx),
                           q.rd_phase ? {DATA_BITS{1'b0}} : q.shadow[d][q.idx]};
        end
    end

    always_comb begin
        logic miss_now;
        n        = q;
        n.start  = 1'b0;
        n.pend   = q.pend | cfg_req;
        miss_now = q.miss;
        unique case (q.st)
            SQ_IDLE: begin
                if (q.pend) begin
                    n.pend     = cfg_req;
                    n.shadow   = cfg_words;
                    n.done     = 1'b0;
                    n.err      = 1'b0;
                    n.retry    = '0;
                    n.rd_phase = 1'b0;
                    n.idx      = '0;
                    n.miss     = 1'b0;
                    n.st       = SQ_LAUNCH;
                end
            end
            SQ_LAUNCH: begin
                n.start = 1'b1;
                n.st    = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (ser_fin) begin
                    if (q.rd_phase) begin
                        for (int d = 0; d < N_DEV; d++) begin
                            if (ser_rx[d] != q.shadow[d][q.idx]) miss_now = 1'b1;
                        end
                    end
                    if (q.idx == IDX_LAST) begin
                        n.idx = '0;
                        if (!q.rd_phase) begin
                            n.rd_phase = 1'b1;
                            n.st       = SQ_LAUNCH;
                        end else if (miss_now) begin
                            n.miss = 1'b0;
                            if (q.retry == RTY_LIMIT) begin
                                n.err = 1'b1;
                                n.st  = SQ_IDLE;
                            end else begin
                                n.retry    = q.retry + 1'b1;
                                n.rd_phase = 1'b0;
                                n.st       = SQ_LAUNCH;
                            end
                        end else begin
                            n.done = 1'b1;
                            n.st   = SQ_IDLE;
                        end
                    end else begin
                        n.idx  = q.idx + 1'b1;
                        n.miss = miss_now;
                        n.st   = SQ_LAUNCH;
                    end
                end
            end
            default: n.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SQ_IDLE;
        end else begin
            q <= n;
        end
    end

    assign cfg_done = q.done;
    assign cfg_err  = q.err;

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_done && cfg_err)); // R11
    AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done || cfg_err) |-> (q.st == SQ_IDLE)); // R7
    AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(ser_fin)); // R5
    AST_ERR_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(ser_fin)); // R7
    AST_NO_RETRY_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        q.retry <= RTY_LIMIT); // R6
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |-> pll_csn); // R2

endmodule

// File: tb/pllcfg_ctrl_bench.sv
module pllcfg_ctrl_bench;

    localparam int NDEV = 2;
    localparam int NREG = 4;
    localparam int W    = NDEV*NREG*8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [W-1:0]    cfg_words = '0;
    logic            cfg_req = 1'b0;
    logic [NDEV-1:0] fsync = '0;
    logic [NDEV-1:0] pll_ref;
    logic            pll_sclk;
    logic            pll_csn;
    logic [NDEV-1:0] pll_mosi;
    logic [NDEV-1:0] pll_miso;
    logic            cfg_done;
    logic            cfg_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pllcfg_ctrl u_pllcfg_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_words(cfg_words), .cfg_req(cfg_req),
        .fsync(fsync), .pll_ref(pll_ref), .pll_sclk(pll_sclk), .pll_csn(pll_csn),
        .pll_mosi(pll_mosi), .pll_miso(pll_miso), .cfg_done(cfg_done), .cfg_err(cfg_err)
    );

    // ---------------- device model ----------------
    int          bitcnt = 0;
    logic [15:0] sh    [NDEV];
    logic [7:0]  abyte [NDEV];
    logic [7:0]  mem   [NDEV][NREG];
    logic [7:0]  alog  [NDEV][64];
    int          nframe [NDEV];
    int          wr2cnt [NDEV];
    int          quota  [NDEV];
    int          epoch = 0;
    int          seen_epoch = 0;

    initial begin
        for (int d = 0; d < NDEV; d++) begin
            quota[d] = 0; nframe[d] = 0; wr2cnt[d] = 0;
            sh[d] = '0; abyte[d] = '0;
            for (int r = 0; r < NREG; r++) mem[d][r] = '0;
        end
    end

    always @(posedge pll_sclk or negedge pll_csn) begin
        if (!pll_sclk) begin
            bitcnt = 0;
            if (epoch != seen_epoch) begin
                seen_epoch = epoch;
                for (int d = 0; d < NDEV; d++) begin nframe[d] = 0; wr2cnt[d] = 0; end
            end
        end else if (!pll_csn) begin
            bitcnt++;
            for (int d = 0; d < NDEV; d++) begin
                sh[d] = {sh[d][14:0], pll_mosi[d]};
                if (bitcnt == 8) abyte[d] = sh[d][7:0];
                if (bitcnt == 16) begin
                    if (nframe[d] < 64) alog[d][nframe[d]] = sh[d][15:8];
                    nframe[d]++;
                    if (!sh[d][15] && sh[d][14:10] == 5'b00100) begin
                        if (sh[d][9:8] == 2'd2) begin
                            mem[d][2] = (wr2cnt[d] < quota[d]) ? (sh[d][7:0] ^ 8'h01) : sh[d][7:0];
                            wr2cnt[d]++;
                        end else begin
                            mem[d][sh[d][9:8]] = sh[d][7:0];
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        for (int d = 0; d < NDEV; d++) begin
            if (bitcnt >= 8 && bitcnt < 16 && abyte[d][7] && abyte[d][6:2] == 5'b00100)
                pll_miso[d] = mem[d][abyte[d][1:0]][15-bitcnt];
            else
                pll_miso[d] = 1'b0;
        end
    end

    // ---------------- monitor ----------------
    int viol = 0;
    int both = 0;
    int dbl  = 0;
    int refcnt [NDEV];
    logic [NDEV-1:0] ref_prev = '0;
    initial for (int i = 0; i < NDEV; i++) refcnt[i] = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pll_sclk && pll_csn) viol++;
            if (cfg_done && cfg_err) both++;
            for (int i = 0; i < NDEV; i++) begin
                if (pll_ref[i] && ref_prev[i]) dbl++;
                if (pll_ref[i]) refcnt[i]++;
            end
            ref_prev = pll_ref;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_req();
        @(negedge clk); cfg_req = 1'b1;
        @(negedge clk); cfg_req = 1'b0;
    endtask

    task automatic wait_result(output bit timed_out);
        int n = 0;
        timed_out = 1'b0;
        repeat (4) @(negedge clk);
        while (!cfg_done && !cfg_err && n < 20000) begin @(negedge clk); n++; end
        if (n >= 20000) timed_out = 1'b1;
    endtask

    task automatic fill_cfg(input logic [7:0] seed);
        for (int i = 0; i < NDEV*NREG; i++) cfg_words[i*8 +: 8] = seed + 8'(i*37);
    endtask

    task automatic check_mem(input string req);
        for (int d = 0; d < NDEV; d++)
            for (int r = 0; r < NREG; r++)
                chk(mem[d][r] == cfg_words[(d*NREG+r)*8 +: 8], req, "device byte",
                    int'(mem[d][r]), int'(cfg_words[(d*NREG+r)*8 +: 8]));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(pll_csn == 1'b1, "R1", "csn in reset", int'(pll_csn), 1);
        chk(pll_sclk == 1'b0, "R1", "sclk in reset", int'(pll_sclk), 0);
        chk(cfg_done == 1'b0 && cfg_err == 1'b0, "R1", "status in reset", int'({cfg_done, cfg_err}), 0);
        chk(pll_ref == '0, "R1", "ref in reset", int'(pll_ref), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_basic();
        bit to;
        epoch++;
        fill_cfg(8'h5A);
        pulse_req();
        wait_result(to);
        chk(!to && cfg_done && !cfg_err, "R5", "clean pass done", int'({cfg_done, cfg_err}), 2);
        chk(nframe[0] == 8 && nframe[1] == 8, "R3", "frames in one pass", nframe[0], 8);
        for (int k = 0; k < 8; k++) begin
            logic [7:0] exp = {k >= 4 ? 1'b1 : 1'b0, 7'(7'h10 + (k % 4))};
            chk(alog[0][k] == exp, "R3", "address byte order", int'(alog[0][k]), int'(exp));
            chk(alog[1][k] == exp, "R2", "read flag bit 15", int'(alog[1][k]), int'(exp));
        end
        check_mem("R4");
        chk(mem[0][0] != mem[1][0], "R4", "devices get distinct bytes", int'(mem[1][0]), -1);
        chk(viol == 0, "R2", "sclk high with csn high", viol, 0);
    endtask

    task automatic t_done_clear();
        pulse_req();
        @(negedge clk);
        chk(cfg_done == 1'b0, "R8", "done cleared on accept", int'(cfg_done), 0);
        begin bit to; wait_result(to); end
    endtask

    task automatic t_retry_once();
        bit to;
        quota[1] = 1;
        epoch++;
        fill_cfg(8'h13);
        pulse_req();
        wait_result(to);
        chk(!to && cfg_done && !cfg_err, "R6", "done after one retry", int'({cfg_done, cfg_err}), 2);
        chk(nframe[1] == 16, "R6", "frames with one retry", nframe[1], 16);
        check_mem("R5");
    endtask

    task automatic t_exhaust();
        bit to;
        int f;
        quota[0] = 100; quota[1] = 0;
        epoch++;
        fill_cfg(8'hC4);
        pulse_req();
        wait_result(to);
        chk(!to && cfg_err && !cfg_done, "R7", "error after last retry", int'({cfg_done, cfg_err}), 1);
        chk(nframe[0] == 32, "R6", "frames before giving up", nframe[0], 32);
        f = nframe[0];
        repeat (600) @(negedge clk);
        chk(nframe[0] == f, "R7", "no frames after error", nframe[0], f);
        chk(cfg_err == 1'b1, "R7", "error held", int'(cfg_err), 1);
    endtask

    task automatic t_recover();
        bit to;
        quota[0] = 0;
        epoch++;
        fill_cfg(8'h77);
        pulse_req();
        @(negedge clk);
        chk(cfg_err == 1'b0, "R8", "error cleared on accept", int'(cfg_err), 0);
        wait_result(to);
        chk(!to && cfg_done && !cfg_err, "R8", "pass after recovery", int'({cfg_done, cfg_err}), 2);
        chk(both == 0, "R11", "done and err together", both, 0);
    endtask

    task automatic t_busy_req();
        bit to;
        int n = 0;
        epoch++;
        fill_cfg(8'h21);
        pulse_req();
        repeat (150) @(negedge clk);
        fill_cfg(8'hE9);
        pulse_req();
        while (nframe[0] < 16 && n < 20000) begin @(negedge clk); n++; end
        wait_result(to);
        chk(!to && cfg_done, "R9", "second pass done", int'(cfg_done), 1);
        chk(nframe[0] == 16, "R9", "frames for two passes", nframe[0], 16);
        check_mem("R9");
    endtask

    task automatic t_ref();
        int c0, c1;
        @(negedge clk); fsync[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk(pll_ref[0] == 1'b0, "R10", "no early strobe", int'(pll_ref[0]), 0);
        @(posedge clk); @(negedge clk);
        chk(pll_ref[0] == 1'b1, "R10", "strobe on third edge", int'(pll_ref[0]), 1);
        chk(pll_ref[1] == 1'b0, "R10", "other bus quiet", int'(pll_ref[1]), 0);
        @(negedge clk);
        chk(pll_ref[0] == 1'b0, "R10", "strobe one cycle", int'(pll_ref[0]), 0);
        c0 = refcnt[0]; c1 = refcnt[1];
        repeat (20) @(negedge clk);
        fsync[0] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            fsync[1] = 1'b1; repeat (4) @(negedge clk);
            fsync[1] = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        chk(refcnt[0] == c0, "R10", "held level no repeat", refcnt[0] - c0, 0);
        chk(refcnt[1] - c1 == 3, "R10", "one strobe per edge", refcnt[1] - c1, 3);
        chk(dbl == 0, "R10", "wide strobes", dbl, 0);
    endtask

    initial begin
        t_reset();
        t_ref();
        t_basic();
        t_done_clear();
        t_retry_once();
        t_exhaust();
        t_recover();
        t_busy_req();
        chk(viol == 0, "R2", "select/clock relation overall", viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20ns * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule